// File: doc/BRIEF.md
# Serial Auto-Baud Synchronizer

This block listens on an asynchronous serial receive line and learns the remote host's bit rate. The host opens with a question mark (0x3F). The block times that character's start bit in cycles of the local clock and keeps the count as the baud divisor. Its own 8N1 receiver and transmitter then run at that divisor.

Once the divisor is loaded, the block sends a fixed greeting, "Synchronized" followed by carriage return and line feed. The host must echo that text back one byte at a time. Each echoed byte is compared with the expected byte in order. A complete and correct echo is answered with "OK" plus carriage return and line feed, and the block then reports itself locked. A wrong byte, a bad stop bit, or silence for too long raises the failed flag, and the block waits for a new question mark.

After lock, the divisor output is meant to drive the baud generator of whatever handles commands next. Reset restarts the whole procedure.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, `tx_o` is high, `divisor_o` is 0, and `locked_o` and `failed_o` are both low.
- R2: Serial framing is 8N1, LSB first, idle high. A question mark (0x3F) gives a low start bit, six high bits, two low bits and a high stop bit. When such a character is accepted, `divisor_o` becomes the number of clock cycles the start bit stayed low.
- R3: The following are not accepted and leave `divisor_o` and `tx_o` unchanged: a low pulse shorter than `MIN_BIT` cycles; a following high span outside 5.5 to 6.5 times the first low span; a second low span outside 1.5 to 2.5 times the first low span. Examples of rejected characters are 0x41, 0x1F and 0x7F.
- R4: After acceptance, the block sends the 14 bytes "Synchronized", 0x0D, 0x0A. They are sent in 8N1 format, LSB first, and each bit lasts `divisor_o` cycles.
- R5: The echo receiver samples each bit near its middle: the start bit is checked half a divisor after the falling edge, and each later bit one divisor after the one before. Echoed bytes are compared in order with the greeting, and a stop bit that reads low counts as a mismatch.
- R6: A complete and correct echo is answered with the 4 bytes "OK", 0x0D, 0x0A. After the last of them, `locked_o` rises and stays high. From then on, `divisor_o` and `tx_o` ignore any further receive activity.
- R7: On a mismatched echo byte, `failed_o` rises, `locked_o` stays low, nothing is transmitted, and the block waits for a new question mark.
- R8: If no echo byte arrives within `TIMEOUT_CYC` cycles of entering the echo phase or of the previous echo byte, `failed_o` rises.
- R9: A question mark accepted after a failure clears `failed_o`, reloads `divisor_o` with the new bit time, and starts the greeting again.
- R10: `locked_o` and `failed_o` are never high together, and `tx_o` stays high while `failed_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| divisor_o | output | CNT_W | Measured bit time in clock cycles |
| locked_o | output | 1 | Handshake complete |
| failed_o | output | 1 | Last attempt failed through a mismatch or timeout |

## Verification
The bench builds the block with `CNT_W` = 12, `MIN_BIT` = 4 and `TIMEOUT_CYC` = 3000. With a 3000-cycle timeout, the silence case both before and after expiry fits within the run. The bit times the bench uses run from 6 to 40 cycles. Short bit times push mid-bit sampling to its narrowest margin, and long ones exercise the wide span counters and the shape window bounds. With a 12-bit divisor, the overflow path of the low-span counter stays within reach, without the bench needing millions of cycles.

// File: rtl/autobaud_pkg.sv
`timescale 1ns/1ps
// Shared types and fixed text for the auto-baud synchronizer.
// Assumes the 7-bit ASCII codes of the greeting and the acknowledgement.
package autobaud_pkg;
    localparam int GREET_LEN = 14;
    localparam int ACK_LEN   = 4;

    typedef enum logic [2:0] {ST_HUNT, ST_GREET, ST_ECHO, ST_ACK, ST_DONE} sync_state_e;
    typedef enum logic [1:0] {M_IDLE, M_LOW1, M_HIGH, M_LOW2} meter_state_e;
    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_e;

    // Greeting byte at position i
    function automatic logic [7:0] greet_char(input logic [3:0] i);
        case (i)
            4'd0:  return 8'h53;
            4'd1:  return 8'h79;
            4'd2:  return 8'h6E;
            4'd3:  return 8'h63;
            4'd4:  return 8'h68;
            4'd5:  return 8'h72;
            4'd6:  return 8'h6F;
            4'd7:  return 8'h6E;
            4'd8:  return 8'h69;
            4'd9:  return 8'h7A;
            4'd10: return 8'h65;
            4'd11: return 8'h64;
            4'd12: return 8'h0D;
            4'd13: return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    // Acknowledgement byte at position i
    function automatic logic [7:0] ack_char(input logic [3:0] i);
        case (i)
            4'd0:    return 8'h4F;
            4'd1:    return 8'h4B;
            4'd2:    return 8'h0D;
            4'd3:    return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/ab_meter.sv
`timescale 1ns/1ps
// Bit-time meter. Times the start bit of a question-mark character and
// accepts it only if the high and low spans that follow match that
// character's shape (six bits high, then two bits low).
// Assumes line_i is already synchronized to clk.
module ab_meter #(
    parameter int CNT_W   = 16,
    parameter int MIN_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             line_i,
    output logic             done_o,
    output logic [CNT_W-1:0] bit_cyc_o
);
    import autobaud_pkg::*;

    localparam int WW = CNT_W + 4;
    localparam logic [WW-1:0] SAT  = {4'b0, {CNT_W{1'b1}}};
    localparam logic [WW-1:0] MINX = WW'(MIN_BIT);

    meter_state_e    ms;
    logic [WW-1:0]   cnt;
    logic [CNT_W-1:0] lo1;
    logic            line_d;
    logic [WW-1:0]   b, hi_min, hi_max, lo_min, lo_max;

    // Acceptance windows derived from the first low span
    always_comb begin
        b      = {4'b0, lo1};
        hi_min = ((b << 3) + (b << 1) + b) >> 1;
        hi_max = ((b << 3) + (b << 2) + b) >> 1;
        lo_min = ((b << 1) + b) >> 1;
        lo_max = ((b << 2) + b) >> 1;
    end

    // Span timing and shape check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms     <= M_IDLE;
            cnt    <= '0;
            lo1    <= '0;
            done_o <= 1'b0;
            line_d <= 1'b1;
        end else begin
            line_d <= line_i;
            done_o <= 1'b0;
            if (!en_i) begin
                ms <= M_IDLE;
            end else begin
                case (ms)
                    M_IDLE: begin
                        if (line_d && !line_i) begin
                            ms  <= M_LOW1;
                            cnt <= WW'(1);
                        end
                    end
                    M_LOW1: begin
                        if (!line_i) begin
                            if (cnt == SAT) ms <= M_IDLE;
                            else            cnt <= cnt + WW'(1);
                        end else if (cnt < MINX) begin
                            ms <= M_IDLE;
                        end else begin
                            lo1 <= cnt[CNT_W-1:0];
                            cnt <= WW'(1);
                            ms  <= M_HIGH;
                        end
                    end
                    M_HIGH: begin
                        if (line_i) begin
                            if (cnt > hi_max) ms <= M_IDLE;
                            else              cnt <= cnt + WW'(1);
                        end else if (cnt >= hi_min) begin
                            cnt <= WW'(1);
                            ms  <= M_LOW2;
                        end else begin
                            ms <= M_IDLE;
                        end
                    end
                    M_LOW2: begin
                        if (!line_i) begin
                            if (cnt > lo_max) ms <= M_IDLE;
                            else              cnt <= cnt + WW'(1);
                        end else begin
                            done_o <= (cnt >= lo_min);
                            ms     <= M_IDLE;
                        end
                    end
                    default: ms <= M_IDLE;
                endcase
            end
        end
    end

    assign bit_cyc_o = lo1;
endmodule

// File: rtl/ab_rx.sv
`timescale 1ns/1ps
// Minimal 8N1 receiver. Samples at mid-bit using half the divisor after the
// start edge. Reports each byte, and a stop-bit error, at the stop-bit sample.
// Assumes line_i is synchronized and div_i >= 4 while en_i is high.
module ab_rx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             valid_o,
    output logic [7:0]       data_o,
    output logic             ferr_o
);
    import autobaud_pkg::*;

    rx_state_e        rs;
    logic [CNT_W-1:0] cyc;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             line_d;
    logic [CNT_W-1:0] half;

    assign half = div_i >> 1;

    // Frame reception
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs      <= R_IDLE;
            cyc     <= '0;
            bitn    <= '0;
            sh      <= '0;
            line_d  <= 1'b1;
            valid_o <= 1'b0;
            data_o  <= '0;
            ferr_o  <= 1'b0;
        end else begin
            line_d  <= line_i;
            valid_o <= 1'b0;
            if (!en_i) begin
                rs <= R_IDLE;
            end else begin
                case (rs)
                    R_IDLE: begin
                        if (line_d && !line_i) begin
                            rs  <= R_START;
                            cyc <= CNT_W'(1);
                        end
                    end
                    R_START: begin
                        if (cyc == half) begin
                            cyc  <= CNT_W'(1);
                            bitn <= '0;
                            rs   <= line_i ? R_IDLE : R_DATA;
                        end else begin
                            cyc <= cyc + CNT_W'(1);
                        end
                    end
                    R_DATA: begin
                        if (cyc == div_i) begin
                            sh  <= {line_i, sh[7:1]};
                            cyc <= CNT_W'(1);
                            if (bitn == 3'd7) rs <= R_STOP;
                            else              bitn <= bitn + 3'd1;
                        end else begin
                            cyc <= cyc + CNT_W'(1);
                        end
                    end
                    R_STOP: begin
                        if (cyc == div_i) begin
                            valid_o <= 1'b1;
                            data_o  <= sh;
                            ferr_o  <= !line_i;
                            rs      <= R_IDLE;
                        end else begin
                            cyc <= cyc + CNT_W'(1);
                        end
                    end
                    default: rs <= R_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ab_tx.sv
`timescale 1ns/1ps
// Minimal 8N1 transmitter. Each bit is held for div_i cycles. It accepts a
// byte when ready_o is high.
// Assumes div_i stays constant while a frame is on the line.
module ab_tx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_i,
    input  logic             start_i,
    input  logic [7:0]       data_i,
    output logic             ready_o,
    output logic             line_o
);
    logic             busy;
    logic [9:0]       sh;
    logic [3:0]       bitn;
    logic [CNT_W-1:0] cyc;

    // Frame shifting and bit timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sh     <= '0;
            bitn   <= '0;
            cyc    <= '0;
            line_o <= 1'b1;
        end else if (!busy) begin
            if (start_i) begin
                busy   <= 1'b1;
                sh     <= {1'b1, data_i, 1'b0};
                bitn   <= '0;
                cyc    <= CNT_W'(1);
                line_o <= 1'b0;
            end
        end else if (cyc == div_i) begin
            cyc <= CNT_W'(1);
            if (bitn == 4'd9) begin
                busy   <= 1'b0;
                line_o <= 1'b1;
            end else begin
                bitn   <= bitn + 4'd1;
                sh     <= sh >> 1;
                line_o <= sh[1];
            end
        end else begin
            cyc <= cyc + CNT_W'(1);
        end
    end

    assign ready_o = !busy;
endmodule

// File: rtl/autobaud_sync.sv
`timescale 1ns/1ps
// Auto-baud synchronizer top. Measures the bit time of the host's question
// mark, sends the greeting, checks the echo byte by byte, and acknowledges.
// Assumes the bit time is at least MIN_BIT cycles. rx_i is asynchronous.
module autobaud_sync #(
    parameter int CNT_W       = 16,
    parameter int MIN_BIT     = 4,
    parameter int TIMEOUT_CYC = 12_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    output logic             tx_o,
    output logic [CNT_W-1:0] divisor_o,
    output logic             locked_o,
    output logic             failed_o
);
    import autobaud_pkg::*;

    localparam int IDX_W = $clog2(GREET_LEN + 1);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [IDX_W-1:0] GREET_END  = IDX_W'(GREET_LEN);
    localparam logic [IDX_W-1:0] GREET_LAST = IDX_W'(GREET_LEN - 1);
    localparam logic [IDX_W-1:0] ACK_END    = IDX_W'(ACK_LEN);
    localparam logic [TO_W-1:0]  TO_LIMIT   = TO_W'(TIMEOUT_CYC - 1);

    sync_state_e      st;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] divisor_q;
    logic             failed_q;
    logic [TO_W-1:0]  to_cnt;
    logic [1:0]       rx_ff;
    logic             rx_s;
    logic             m_done;
    logic [CNT_W-1:0] m_bit;
    logic             rx_valid, rx_ferr;
    logic [7:0]       rx_data;
    logic             tx_ready, tx_start;
    logic [7:0]       tx_byte;

    // Two-stage synchronizer for the receive line
    always_ff @(posedge clk) begin
        if (!rst_n) rx_ff <= 2'b11;
        else        rx_ff <= {rx_ff[0], rx_i};
    end
    assign rx_s = rx_ff[1];

    ab_meter #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) meter_i (
        .clk(clk), .rst_n(rst_n), .en_i(st == ST_HUNT), .line_i(rx_s),
        .done_o(m_done), .bit_cyc_o(m_bit)
    );

    ab_rx #(.CNT_W(CNT_W)) rx_i0 (
        .clk(clk), .rst_n(rst_n), .en_i(st == ST_ECHO), .line_i(rx_s),
        .div_i(divisor_q), .valid_o(rx_valid), .data_o(rx_data), .ferr_o(rx_ferr)
    );

    ab_tx #(.CNT_W(CNT_W)) tx_i0 (
        .clk(clk), .rst_n(rst_n), .div_i(divisor_q), .start_i(tx_start),
        .data_i(tx_byte), .ready_o(tx_ready), .line_o(tx_o)
    );

    // Pick the next outgoing byte and launch it when the transmitter is free
    always_comb begin
        tx_byte  = (st == ST_ACK) ? ack_char(4'(idx)) : greet_char(4'(idx));
        tx_start = tx_ready && (((st == ST_GREET) && (idx != GREET_END)) ||
                                ((st == ST_ACK)   && (idx != ACK_END)));
    end

    // Handshake sequencing, echo comparison and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_HUNT;
            idx       <= '0;
            divisor_q <= '0;
            failed_q  <= 1'b0;
            to_cnt    <= '0;
        end else begin
            case (st)
                ST_HUNT: begin
                    if (m_done) begin
                        divisor_q <= m_bit;
                        failed_q  <= 1'b0;
                        idx       <= '0;
                        st        <= ST_GREET;
                    end
                end
                ST_GREET: begin
                    if (tx_ready) begin
                        if (idx == GREET_END) begin
                            idx    <= '0;
                            to_cnt <= '0;
                            st     <= ST_ECHO;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_ECHO: begin
                    if (rx_valid) begin
                        to_cnt <= '0;
                        if (rx_ferr || (rx_data != greet_char(4'(idx)))) begin
                            failed_q <= 1'b1;
                            st       <= ST_HUNT;
                        end else if (idx == GREET_LAST) begin
                            idx <= '0;
                            st  <= ST_ACK;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else if (to_cnt == TO_LIMIT) begin
                        failed_q <= 1'b1;
                        st       <= ST_HUNT;
                    end else begin
                        to_cnt <= to_cnt + TO_W'(1);
                    end
                end
                ST_ACK: begin
                    if (tx_ready) begin
                        if (idx == ACK_END) st  <= ST_DONE;
                        else                idx <= idx + IDX_W'(1);
                    end
                end
                default: st <= ST_DONE;
            endcase
        end
    end

    assign divisor_o = divisor_q;
    assign locked_o  = (st == ST_DONE);
    assign failed_o  = failed_q;
endmodule

// File: rtl/autobaud_sync_chk.sv
`timescale 1ns/1ps
// Property checker for autobaud_sync, attached through bind below.
// Assumes synchronous active-low reset on the same clock.
module autobaud_sync_chk #(
    parameter int CNT_W   = 16,
    parameter int MIN_BIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_o,
    input logic [CNT_W-1:0] divisor_o,
    input logic             locked_o,
    input logic             failed_o
);
    // R10: the two status flags exclude each other
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && failed_o));

    // R10: no transmission while failed
    a_r10_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |-> tx_o);

    // R6: lock is permanent until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R6: divisor frozen after lock
    a_r6_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(divisor_o));

    // R3: any newly loaded divisor respects the minimum pulse width
    a_r3_div_min: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divisor_o) |-> (divisor_o >= CNT_W'(MIN_BIT)));
endmodule

bind autobaud_sync autobaud_sync_chk #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .divisor_o(divisor_o),
    .locked_o(locked_o), .failed_o(failed_o)
);

// File: tb/autobaud_sync_tb_top.sv
`timescale 1ns/1ps
module autobaud_sync_tb_top;
    localparam int CW  = 12;
    localparam int MINB = 4;
    localparam int TOC = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic tx;
    logic [CW-1:0] div;
    logic locked, failed;

    int n_chk = 0;
    int n_bad = 0;
    string greet = "Synchronized\r\n";
    string ackstr = "OK\r\n";

    always #2.5 clk = ~clk;

    autobaud_sync #(.CNT_W(CW), .MIN_BIT(MINB), .TIMEOUT_CYC(TOC)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
        .divisor_o(div), .locked_o(locked), .failed_o(failed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Host-side 8N1 frame, LSB first, stop held for stop_len cycles
    task automatic send_frame(input logic [7:0] b, input int bt, input int stop_len);
        @(negedge clk);
        rx = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (bt) @(negedge clk);
        end
        rx = 1'b1;
        repeat (stop_len) @(negedge clk);
    endtask

    // Host-side receiver: mid-bit sampling of tx
    task automatic get_byte(input int bt, output logic [7:0] b, output bit got);
        got = 1'b0;
        b = '0;
        for (int k = 0; k < 40000; k++) begin
            @(posedge clk); #1;
            if (!tx) begin
                got = 1'b1;
                break;
            end
        end
        if (got) begin
            repeat (bt / 2) @(posedge clk);
            #1;
            if (tx) got = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (bt) @(posedge clk);
                #1;
                b[i] = tx;
            end
            repeat (bt) @(posedge clk);
            #1;
            if (!tx) got = 1'b0;
        end
    endtask

    task automatic expect_str(input int bt, input string s, input string req);
        logic [7:0] b;
        bit got;
        for (int i = 0; i < s.len(); i++) begin
            get_byte(bt, b, got);
            chk(got && (b == s[i]), req, int'(b), int'(s[i]));
        end
    endtask

    task automatic quiet(input int n, output bit q);
        q = 1'b1;
        repeat (n) begin
            @(posedge clk); #1;
            if (!tx) q = 1'b0;
        end
    endtask

    // R2, R4: send the question mark and read the greeting
    task automatic lock_seq(input int bt);
        fork
            send_frame(8'h3F, bt, 0);
            expect_str(bt, greet, "R4 greeting byte");
        join
        chk(div == CW'(bt), "R2 divisor", int'(div), bt);
    endtask

    // R5: echo the greeting at the host bit time, mid-bit sampled by the DUT
    task automatic echo_str(input int bt, input int upto, input int bad_at);
        repeat (bt) @(negedge clk);
        for (int i = 0; i < upto; i++)
            send_frame((i == bad_at) ? (greet[i] ^ 8'h20) : greet[i], bt, bt);
    endtask

    task automatic full_handshake(input int bt);
        lock_seq(bt);
        fork
            echo_str(bt, 14, -1);
            expect_str(bt, ackstr, "R6 ack byte");
        join
        repeat (2 * bt) @(posedge clk);
        #1;
        chk(locked == 1'b1, "R6 locked", int'(locked), 1);
        chk(failed == 1'b0, "R10 no fail on lock", int'(failed), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit q;
        int bt;
        void'($urandom(32'd4711));

        do_reset();
        @(posedge clk); #1;
        // R1 reset state
        chk(tx == 1'b1, "R1 tx idle", int'(tx), 1);
        chk(div == '0, "R1 divisor", int'(div), 0);
        chk(locked == 1'b0, "R1 locked", int'(locked), 0);
        chk(failed == 1'b0, "R1 failed", int'(failed), 0);

        // R3 short glitch ignored
        @(negedge clk); rx = 1'b0;
        repeat (3) @(negedge clk); rx = 1'b1;
        quiet(200, q);
        chk(q, "R3 glitch quiet", int'(q), 1);
        chk(div == '0, "R3 glitch divisor", int'(div), 0);

        // R3 characters with the wrong shape are rejected
        send_frame(8'h41, 10, 10);
        send_frame(8'h1F, 10, 10);
        send_frame(8'h7F, 10, 10);
        quiet(300, q);
        chk(q, "R3 shape quiet", int'(q), 1);
        chk(div == '0, "R3 shape divisor", int'(div), 0);

        // R2 R4 R5 R6 directed handshake
        full_handshake(12);

        // R6 input ignored after lock
        send_frame(8'h3F, 20, 20);
        quiet(200, q);
        chk(q, "R6 quiet after lock", int'(q), 1);
        chk(div == CW'(12), "R6 divisor frozen", int'(div), 12);
        chk(locked == 1'b1, "R6 still locked", int'(locked), 1);

        // R7 mismatched echo
        do_reset();
        lock_seq(9);
        echo_str(9, 6, 5);
        repeat (3) @(posedge clk); #1;
        chk(failed == 1'b1, "R7 failed", int'(failed), 1);
        chk(locked == 1'b0, "R7 not locked", int'(locked), 0);
        quiet(300, q);
        chk(q, "R7 quiet after fail", int'(q), 1);

        // R9 new question mark after failure
        lock_seq(15);
        chk(failed == 1'b0, "R9 failed cleared", int'(failed), 0);

        // R8 silence timeout
        repeat (TOC - 100) @(posedge clk); #1;
        chk(failed == 1'b0, "R8 before timeout", int'(failed), 0);
        repeat (200) @(posedge clk); #1;
        chk(failed == 1'b1, "R8 after timeout", int'(failed), 1);
        chk(locked == 1'b0, "R8 not locked", int'(locked), 0);

        // Random bit times, full handshakes (R2 R4 R5 R6)
        for (int r = 0; r < 4; r++) begin
            do_reset();
            bt = 6 + int'($urandom % 35);
            full_handshake(bt);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule